// File: doc/BRIEF.md
# Variable-Length Serial Peripheral Master

This block is a serial peripheral master that shifts one word of 8, 16, 24 or 32 bits per transfer. Software sets up a 32-bit control word and then writes the data word. That write starts the transfer, provided the unit is enabled and not already busy. While the transfer runs, the block drives the serial clock and the outgoing data line and samples the incoming data line. The received bits can then be read back from the data side, right-aligned.

Eight active-low select lines follow the control word directly and never change on their own. Software therefore frames a transaction by setting a select bit before the data write and clearing it afterwards. The clock divider, idle clock level, bit order and word length can all be set. An optional one-cycle interrupt pulse marks the end of each transfer.

Top module: `spi_len_master`

## Requirements
- R1: After reset, all eight select lines are high, the serial clock and outgoing data are low, the busy flag (control read bit 31) is 0, the interrupt is low and the received word reads 0.
- R2: Control bits 7:0 drive the select lines: a 1 in bit k holds line k low and a 0 holds it high, whether or not a transfer is running.
- R3: Control bit 8 is the enable; a data write while it is 0 starts nothing: busy stays 0, the clock shows no edge and the received word is unchanged.
- R4: Control bit 9 gives the idle clock level; the clock sits at that level whenever busy is 0, and the first edge of each bit moves it away from that level.
- R5: Control bits 12:10 choose the divider D from values 0..7 as 2, 4, 8, 64, 128, 1024, 2048, 4096; each clock half period lasts D cycles, so busy stays high for exactly 2*N*D cycles for an N-bit word.
- R6: Control bit 13 picks the order: 0 sends and receives bit N-1 first down to bit 0, 1 sends bit 0 first up to bit N-1.
- R7: Control bits 15:14 set the length N: 00 is 8, 01 is 16, 10 is 24, 11 is 32; each transfer has exactly N leading clock edges.
- R8: The outgoing line takes each new bit on the edge that leaves the idle level, and the incoming line is sampled on the edge that returns to it; the received word holds the N bits in positions N-1..0, and the bits above them read 0.
- R9: The control read returns bits 16:0 as last written, bit 31 as the busy flag and all other bits 0; a data write while busy is ignored and does not change the running transfer.
- R10: When control bit 16 is set, the interrupt goes high for exactly one cycle, in the cycle after busy falls; when bit 16 is clear, it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| data_we | input | 1 | Write strobe for the data word (starts a transfer) |
| wdata | input | 32 | Write data for either word |
| ctrl_rd | output | 32 | Control readback with busy in bit 31 |
| data_rd | output | 32 | Last received word, right-aligned |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 8 | Active-low select lines |
| irq | output | 1 | Transfer-done pulse |

## Verification
The bench sweeps every combination of idle level, bit order and length over the three shortest dividers, then steps the long dividers with 8-bit words. For each transfer it counts busy cycles, so a wrong divider table entry or an off-by-one in the half-period counter shows up as a wrong cycle count. A slave model records the outgoing bits at their word positions and drives the incoming bits from a known word. A reversed order, a miscounted length or a sample taken on the wrong edge therefore corrupts the captured or received word, or leaves stale upper bits. Further checks cover a data write issued mid-transfer, which a design that restarts would answer with a longer busy time and different data. They also cover a write while disabled, and a missing, doubled or unmasked interrupt pulse.

// File: rtl/spi_len_pkg.sv
package spi_len_pkg;

  localparam int WORD_W = 32;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CS_N   = 8;
  localparam int DIV_W  = 12;
  localparam int CFG_W  = 17;

  typedef struct packed {
    logic            irq_en;
    logic [1:0]      len;
    logic            lsb_first;
    logic [2:0]      div_sel;
    logic            cpol;
    logic            en;
    logic [CS_N-1:0] sel;
  } spi_cfg_t;

  // Last bit index of a transfer: (len+1)*8-1.
  function automatic logic [IDX_W-1:0] last_index(input logic [1:0] len);
    return {len, 3'b111};
  endfunction

  // Half-period length minus one for each divider code.
  function automatic logic [DIV_W-1:0] div_limit(input logic [2:0] code);
    int sh;
    case (code)
      3'd0:    sh = 1;
      3'd1:    sh = 2;
      3'd2:    sh = 3;
      3'd3:    sh = 6;
      3'd4:    sh = 7;
      3'd5:    sh = 10;
      3'd6:    sh = 11;
      default: sh = 12;
    endcase
    return DIV_W'((1 << sh) - 1);
  endfunction

endpackage

// File: rtl/spi_len_rst_sync.sv
module spi_len_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/spi_len_prescaler.sv
module spi_len_prescaler
  import spi_len_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [2:0] code_i,
  output logic       tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] limit;
  logic             cnt_en;

  always_comb begin
    limit  = div_limit(code_i);
    tick_o = run_i && (cnt_q == limit);
    cnt_en = run_i || (cnt_q != '0);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Smallest divider is 2, so two ticks never touch.
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R5

endmodule

// File: rtl/spi_len_engine.sv
module spi_len_engine
  import spi_len_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        len_i,
  input  logic              lsb_first_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              active_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o
);

  logic              busy_q, busy_d;
  logic              act_q, act_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  last_q, last_d;
  logic              lsb_q, lsb_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic              mosi_q, mosi_d;
  logic [IDX_W-1:0]  pos;
  logic              upd;

  always_comb begin
    busy_d = busy_q;
    act_d  = act_q;
    idx_d  = idx_q;
    last_d = last_q;
    lsb_d  = lsb_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    mosi_d = mosi_q;
    done_o = 1'b0;
    pos    = lsb_q ? idx_q : (last_q - idx_q);
    upd    = (!busy_q && start_i) || (busy_q && tick_i);
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        act_d  = 1'b0;
        idx_d  = '0;
        last_d = last_index(len_i);
        lsb_d  = lsb_first_i;
        tx_d   = word_i;
        rx_d   = '0;
      end
    end else if (tick_i) begin
      if (!act_q) begin
        act_d  = 1'b1;
        mosi_d = tx_q[pos];
      end else begin
        act_d     = 1'b0;
        rx_d[pos] = miso_i;
        if (idx_q == last_q) begin
          busy_d = 1'b0;
          done_o = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      lsb_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else if (upd) begin
      busy_q <= busy_d;
      act_q  <= act_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      lsb_q  <= lsb_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      mosi_q <= mosi_d;
    end
  end

  assign busy_o   = busy_q;
  assign active_o = act_q;
  assign mosi_o   = mosi_q;
  assign rx_o     = rx_q;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(tx_q) && $stable(last_q))); // R9
  AST_IDLE_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !act_q); // R4
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && last_q == 5'd7) |-> (rx_q[WORD_W-1:8] == '0)); // R8

endmodule

// File: rtl/spi_len_master.sv
module spi_len_master
  import spi_len_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic        data_we,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_rd,
  output logic [31:0] data_rd,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic [7:0]  cs_n,
  output logic        irq
);

  logic     rst_s_n;
  spi_cfg_t cfg_q, cfg_d;
  logic     irq_q, irq_d;
  logic     start, tick, busy, done, active;

  spi_len_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  always_comb begin
    cfg_d = spi_cfg_t'(wdata[CFG_W-1:0]);
    start = data_we && cfg_q.en;
    irq_d = done && cfg_q.irq_en;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     cfg_q <= '0;
    else if (ctrl_we) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  spi_len_prescaler div_i (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run_i  (busy),
    .code_i (cfg_q.div_sel),
    .tick_o (tick)
  );

  spi_len_engine eng_i (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start_i     (start),
    .word_i      (wdata),
    .len_i       (cfg_q.len),
    .lsb_first_i (cfg_q.lsb_first),
    .tick_i      (tick),
    .miso_i      (miso),
    .busy_o      (busy),
    .done_o      (done),
    .active_o    (active),
    .mosi_o      (mosi),
    .rx_o        (data_rd)
  );

  assign sclk    = cfg_q.cpol ^ active;
  assign cs_n    = ~cfg_q.sel;
  assign irq     = irq_q;
  assign ctrl_rd = {busy, {(31-CFG_W){1'b0}}, cfg_q};

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |=> !irq); // R10
  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> (!busy && $past(busy))); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy |-> (sclk == cfg_q.cpol)); // R4

endmodule

// File: tb/spi_len_master_tb_top.sv
module spi_len_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic        data_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] ctrl_rd, data_rd;
  logic        miso = 1'b0;
  logic        sclk, mosi, irq;
  logic [7:0]  cs_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // slave model state
  int          n_lead, busy_cyc, irq_cnt, cur_n, pos;
  logic [31:0] cap, slave_word;
  logic        prev_sclk = 1'b0;
  bit          cur_cpol = 0, cur_lsb = 0;

  always #4 clk = ~clk;

  spi_len_master dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .data_we(data_we),
    .wdata(wdata), .ctrl_rd(ctrl_rd), .data_rd(data_rd), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .irq(irq)
  );

  always @(posedge clk) begin
    #1;
    if (sclk !== prev_sclk && sclk !== cur_cpol) begin
      pos = cur_lsb ? n_lead : cur_n - 1 - n_lead;
      if (pos >= 0 && pos < 32) begin
        cap[pos] = mosi;
        miso     = slave_word[pos];
      end
      n_lead++;
    end
    prev_sclk = sclk;
    if (ctrl_rd[31] === 1'b1) busy_cyc++;
    if (irq === 1'b1) irq_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_we = 1'b1; wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  function automatic int div_of(input int code);
    int sh [8] = '{1, 2, 3, 6, 7, 10, 11, 12};
    return 1 << sh[code];
  endfunction

  task automatic xfer(input bit cpol, input bit lsb, input int len, input int code,
                      input bit irqen, input logic [31:0] word, input logic [31:0] sw,
                      input bit mid_write);
    logic [7:0]  selv;
    logic [31:0] cv, mask;
    int          n, d;
    selv = 8'h01 << (len + 2 * code);
    cv   = {15'd0, irqen, 2'(len), lsb, 3'(code), cpol, 1'b1, selv};
    n    = (len + 1) * 8;
    d    = div_of(code);
    mask = 32'((64'd1 << n) - 1);
    cur_cpol = cpol; cur_lsb = lsb; cur_n = n; slave_word = sw;
    wr_ctrl(cv);
    repeat (2) @(negedge clk);
    n_lead = 0; busy_cyc = 0; irq_cnt = 0; cap = '0;
    wr_data(word);
    if (mid_write) begin
      repeat (5) @(negedge clk);
      wr_data(~word);
    end
    while (ctrl_rd[31] === 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_lead == n, "R7 leading edges", n_lead, n);
    chk(cap == (word & mask), "R6 R8 outgoing bits", cap, word & mask);
    chk(data_rd == (sw & mask), "R8 received word", data_rd, sw & mask);
    chk(busy_cyc == 2 * n * d, "R5 busy cycles", busy_cyc, 2 * n * d);
    chk(irq_cnt == (irqen ? 1 : 0), "R10 irq pulses", irq_cnt, irqen ? 1 : 0);
    chk(sclk == cpol, "R4 idle level", sclk, cpol);
    chk(cs_n == ~selv, "R2 selects", cs_n, ~selv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n == 8'hFF, "R1 selects", cs_n, 8'hFF);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1 lines", {sclk, mosi}, 0);
    chk(ctrl_rd == 32'd0, "R1 control/busy", ctrl_rd, 0);
    chk(irq == 1'b0 && data_rd == 32'd0, "R1 irq/rx", data_rd, 0);
    // R9 readback masking
    wr_ctrl(32'hFFFF_FEFF);
    chk(ctrl_rd == 32'h0001_FEFF, "R9 readback", ctrl_rd, 32'h0001_FEFF);
    chk(cs_n == 8'h00, "R2 all low", cs_n, 8'h00);
    // main sweep
    for (int cp = 0; cp < 2; cp++)
      for (int lb = 0; lb < 2; lb++)
        for (int ln = 0; ln < 4; ln++)
          for (int c = 0; c < 3; c++)
            xfer(cp[0], lb[0], ln, c, ((ln + c) % 2) == 0,
                 32'hA5C3_0F96 ^ (32'h1357_9BDF * (ln + 1 + 4 * c)),
                 32'h6B2E_D481 + 32'h0101_0101 * (cp + 2 * lb + ln),
                 1'b0);
    // long dividers
    for (int c = 3; c < 8; c++)
      xfer(c[0], c[1], 0, c, 1'b1, 32'hFFFF_FF00 | 32'(8'h3C + c), 32'hFFFF_FF00 | 32'(8'hC1 ^ c), 1'b0);
    // R9 write during transfer ignored
    xfer(1'b0, 1'b0, 3, 0, 1'b1, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1);
    xfer(1'b1, 1'b1, 1, 1, 1'b0, 32'h0000_8001, 32'hFFFF_7FFE, 1'b1);
    // R3 disabled start
    keep = data_rd;
    cur_cpol = 1'b1;
    wr_ctrl(32'h0000_0200);
    n_lead = 0; busy_cyc = 0; irq_cnt = 0;
    wr_data(32'h5555_AAAA);
    repeat (30) @(negedge clk);
    chk(busy_cyc == 0, "R3 busy", busy_cyc, 0);
    chk(n_lead == 0 && sclk == 1'b1, "R3 clock quiet", n_lead, 0);
    chk(data_rd == keep, "R3 rx unchanged", data_rd, keep);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule